// File: doc/BRIEF.md
# Six-Channel Serial Audio Transmitter

This block takes six 20-bit PCM samples in parallel and sends them on one serial data line. The line uses a time-division layout that is framed by a bit clock and a word-select clock. The block makes both clocks itself from the system clock, through a divider that can be set at run time.

Each frame lasts 120 bit-clock periods. The word-select line is high for the first half of the frame, which carries channels 0, 2 and 4 in that order. It is low for the second half, which carries channels 1, 3 and 5. Every slot is 20 bits long and is sent MSB first. The data line and the word-select line change only on a falling edge of the bit clock, so a receiver can sample them on the rising edge.

A producer hands over a set of six samples with a valid/ready handshake. The block holds one pending set, so the next set can be loaded while the current frame is still going out. At each frame boundary the pending set moves into the output shift register. If no set is pending, the previous samples are sent again and an underrun flag is raised for that frame.

Top module: `tdm6_tx`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `sdata_o` is 0, `lrclk_o` is 1, `sclk_o` is 1, `ready_o` is 1 and `underrun_o` is 0.
- R2: Each half period of `sclk_o` lasts `half_div_i`+1 system clock cycles, so a full period lasts 2*(`half_div_i`+1) cycles. The first edge after reset is a falling edge.
- R3: `sdata_o` and `lrclk_o` change only in the system clock cycle in which `sclk_o` goes from 1 to 0.
- R4: A frame lasts 120 `sclk_o` periods. At the rising edges of bits 0 to 59 of the frame, `lrclk_o` is 1. At the rising edges of bits 60 to 119, it is 0.
- R5: The slots go out in this order: channel 0, 2, 4 while `lrclk_o` is 1, then channel 1, 3, 5 while it is 0. Each slot is 20 bits, MSB first. Channel c is taken from `samples_i[20*c+19 : 20*c]`.
- R6: A set is accepted in a cycle where `valid_i` and `ready_o` are both 1. In the next cycle `ready_o` falls, and it stays 0 until a frame boundary takes the set. If `valid_i` is raised while `ready_o` is 0, it has no effect on the data sent.
- R7: A set accepted during a frame is sent in the next frame. A frame starts at the falling edge that puts out bit 0, the MSB of channel 0.
- R8: If no set is pending at a frame boundary, the frame repeats the previous samples and `underrun_o` is 1 for the whole frame. `underrun_o` goes back to 0 at the next boundary that takes a fresh set. After reset, the first frame is all zeros and has `underrun_o` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | DIV_W | Length of an `sclk_o` half period, minus one, in system clocks |
| valid_i | input | 1 | A sample set is offered on `samples_i` |
| samples_i | input | SLOT_W*NCH | Six samples; channel c is at bits [SLOT_W*c +: SLOT_W] |
| ready_o | output | 1 | The pending buffer is free and can accept a set |
| sclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Frame phase: 1 for channels 0/2/4, 0 for channels 1/3/5 |
| sdata_o | output | 1 | Serial data; changes on the falling edge of `sclk_o` |
| underrun_o | output | 1 | The current frame repeats the previous samples |

## Verification
The bench uses the default slot width and channel count, with `DIV_W`=4. It runs twice, once with `half_div_i`=0 and once with `half_div_i`=3. The first setting is the fastest bit clock possible, one system clock per half period. In that setting, the frame-boundary load, the buffer release and the strobe on the falling edge all happen in back-to-back cycles. The second setting stretches each half period to four cycles, which checks that the data and word-select lines stay put between divider ticks. It also checks that the divider reloads correctly. Each run starts with the all-zero underrun frame. It then mixes directed loads, skipped loads and a rejected offer while the buffer is full with a random load pattern.

// File: rtl/tdm6_pkg.sv
package tdm6_pkg;

  // Slot index within a frame -> channel number.
  // First half carries even channels, second half odd ones, ascending.
  function automatic int unsigned slot_chan(int unsigned slot, int unsigned nch);
    return (slot < nch / 2) ? 2 * slot : 2 * (slot - nch / 2) + 1;
  endfunction

endpackage

// File: rtl/tdm6_clkdiv.sv
module tdm6_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             sclk_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  // >= guards against the divider being lowered mid-count
  assign tick = (cnt_q >= half_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = tick & sclk_q;

  AST_SCLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < half_div_i) |=> $stable(sclk_q)); // R2

endmodule

// File: rtl/tdm6_framer.sv
module tdm6_framer #(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned NCH    = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic frame_start_o,
  output logic lrclk_o
);

  localparam int unsigned FRAME_BITS = SLOT_W * NCH;
  localparam int unsigned HALF_BITS  = FRAME_BITS / 2;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HALF_BIT = CNT_W'(HALF_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             started_q;
  logic             lr_q;
  logic             wrap;

  assign wrap          = !started_q || (cnt_q == LAST_BIT);
  assign cnt_d         = wrap ? '0 : cnt_q + 1'b1;
  assign frame_start_o = fall_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      lr_q      <= 1'b1;
    end else if (fall_i) begin
      cnt_q     <= cnt_d;
      started_q <= 1'b1;
      lr_q      <= (cnt_d < HALF_BIT);
    end
  end

  assign lrclk_o = lr_q;

  AST_LR_DROP_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lr_q) |-> (cnt_q == HALF_BIT)); // R4
  AST_LR_RISE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lr_q) |-> (cnt_q == '0)); // R4
  AST_FRAME_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> lr_q); // R7

endmodule

// File: rtl/tdm6_sample_buf.sv
module tdm6_sample_buf #(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned NCH    = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [SLOT_W*NCH-1:0]    samples_i,
  output logic                     ready_o,
  input  logic                     take_i,
  output logic [SLOT_W*NCH-1:0]    set_o,
  output logic                     underrun_o
);

  localparam int unsigned SET_W = SLOT_W * NCH;

  logic [SET_W-1:0] pend_q, cur_q;
  logic             full_q, under_q;
  logic             accept;

  assign ready_o = !full_q;
  assign accept  = valid_i && !full_q;
  assign set_o   = full_q ? pend_q : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      cur_q   <= '0;
      full_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (take_i) begin
        cur_q   <= set_o;
        under_q <= !full_q;
      end
      if (accept) begin
        pend_q <= samples_i;
        full_q <= 1'b1;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign underrun_o = under_q;

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o); // R6
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (full_q && $stable(pend_q))); // R6
  AST_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !full_q) |=> (underrun_o && $stable(cur_q))); // R8
  AST_FRESH_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && full_q) |=> (!underrun_o && cur_q == $past(pend_q))); // R7

endmodule

// File: rtl/tdm6_shifter.sv
module tdm6_shifter #(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned NCH    = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [SLOT_W*NCH-1:0] set_i,
  output logic                  sdata_o
);

  localparam int unsigned FRAME_BITS = SLOT_W * NCH;

  logic [FRAME_BITS-1:0] frame_vec;
  logic [FRAME_BITS-1:0] sr_q;

  // Reorder channels into transmit slots, slot 0 at the MSB end
  for (genvar k = 0; k < NCH; k++) begin : g_slot
    localparam int unsigned CH = tdm6_pkg::slot_chan(k, NCH);
    assign frame_vec[FRAME_BITS-1-k*SLOT_W -: SLOT_W] = set_i[CH*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= frame_vec;
    end else if (shift_i) begin
      sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign sdata_o = sr_q[FRAME_BITS-1];

  AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdata_o == $past(set_i[SLOT_W-1]))); // R5

endmodule

// File: rtl/tdm6_tx.sv
module tdm6_tx #(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned NCH    = 6,
  parameter int unsigned DIV_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIV_W-1:0]      half_div_i,
  input  logic                  valid_i,
  input  logic [SLOT_W*NCH-1:0] samples_i,
  output logic                  ready_o,
  output logic                  sclk_o,
  output logic                  lrclk_o,
  output logic                  sdata_o,
  output logic                  underrun_o
);

  localparam int unsigned SET_W = SLOT_W * NCH;

  logic             fall;
  logic             frame_start;
  logic [SET_W-1:0] set;

  tdm6_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_div_i (half_div_i),
    .sclk_o     (sclk_o),
    .fall_o     (fall)
  );

  tdm6_framer #(.SLOT_W(SLOT_W), .NCH(NCH)) u_framer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fall_i        (fall),
    .frame_start_o (frame_start),
    .lrclk_o       (lrclk_o)
  );

  tdm6_sample_buf #(.SLOT_W(SLOT_W), .NCH(NCH)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .samples_i  (samples_i),
    .ready_o    (ready_o),
    .take_i     (frame_start),
    .set_o      (set),
    .underrun_o (underrun_o)
  );

  tdm6_shifter #(.SLOT_W(SLOT_W), .NCH(NCH)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (frame_start),
    .shift_i (fall),
    .set_i   (set),
    .sdata_o (sdata_o)
  );

  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $fell(sclk_o)); // R3
  AST_LR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(sclk_o)); // R3
  AST_UNDER_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(underrun_o) |-> $fell(sclk_o)); // R8

endmodule

// File: tb/tdm6_tx_bench.sv
module tdm6_tx_bench;

  localparam int unsigned W     = 20;
  localparam int unsigned NCH   = 6;
  localparam int unsigned DW    = 4;
  localparam int unsigned FB    = W * NCH;
  localparam int unsigned HALFB = FB / 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] half_div = '0;
  logic          valid = 1'b0;
  logic [FB-1:0] samples = '0;
  logic          ready, sclk, lrclk, sdata, underrun;

  always #5 clk = ~clk;

  tdm6_tx #(.SLOT_W(W), .NCH(NCH), .DIV_W(DW)) u_tdm6_tx (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .half_div_i (half_div),
    .valid_i    (valid),
    .samples_i  (samples),
    .ready_o    (ready),
    .sclk_o     (sclk),
    .lrclk_o    (lrclk),
    .sdata_o    (sdata),
    .underrun_o (underrun)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected model
  logic [FB-1:0] exp_set [0:15];
  bit            exp_under [0:15];
  int            plan_max = 0;

  function automatic int unsigned chan_of(int unsigned slot);
    return (slot < NCH / 2) ? 2 * slot : 2 * (slot - NCH / 2) + 1;
  endfunction

  function automatic logic [FB-1:0] rand_set();
    logic [127:0] r;
    r = {$urandom(), $urandom(), $urandom(), $urandom()};
    return r[FB-1:0];
  endfunction

  // Receiver model, sampled away from the active edge
  int   rise_cnt = 0;
  int   cyc = 0;
  int   last_rise = 0;
  int   r3_bad = 0;
  bit   lr_bad = 1'b0;
  logic sclk_prev = 1'b1, sd_prev = 1'b0, lr_prev = 1'b1;
  logic [W-1:0] word = '0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      rise_cnt  = 0;
      cyc       = 0;
      last_rise = 0;
      lr_bad    = 1'b0;
      sclk_prev = sclk;
      sd_prev   = sdata;
      lr_prev   = lrclk;
    end else begin
      cyc++;
      // R3: data and phase move only with a falling bit clock
      if ((sdata !== sd_prev || lrclk !== lr_prev) && !(sclk_prev && !sclk)) r3_bad++;
      if (sclk && !sclk_prev) begin
        int idx, fr;
        idx = rise_cnt % FB;
        fr  = rise_cnt / FB;
        if (rise_cnt > 0)
          chk(cyc - last_rise == 2 * (int'(half_div) + 1), "R2 sclk period", cyc - last_rise,
              2 * (int'(half_div) + 1));
        last_rise = cyc;
        if (fr <= plan_max) begin
          if (idx == 0) begin
            chk(underrun == exp_under[fr], "R8 underrun at frame start", underrun, exp_under[fr]);
            chk(ready == 1'b1, "R6 ready after frame take", ready, 1);
          end
          if (lrclk !== (idx < HALFB)) lr_bad = 1'b1;
          word = {word[W-2:0], sdata};
          if (idx % W == W - 1) begin
            int slot, ch;
            slot = idx / W;
            ch   = chan_of(slot);
            // R5 order/MSB first, R7 frame content follows load
            chk(word == exp_set[fr][ch*W +: W], "R5 R7 slot word", word, exp_set[fr][ch*W +: W]);
            chk(!lr_bad, "R4 lrclk level in slot", lr_bad, 0);
            lr_bad = 1'b0;
          end
        end
        rise_cnt++;
      end
      sclk_prev = sclk;
      sd_prev   = sdata;
      lr_prev   = lrclk;
    end
  end

  task automatic do_run(input int hd, input int nfr);
    rst_ni   = 1'b0;
    half_div = DW'(hd);
    valid    = 1'b0;
    r3_bad   = 0;
    exp_set[0]   = '0;
    exp_under[0] = 1'b1;
    plan_max     = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(sdata == 1'b0 && lrclk == 1'b1 && sclk == 1'b1, "R1 line state in reset",
        {sdata, lrclk, sclk}, 3'b011);
    chk(ready == 1'b1 && underrun == 1'b0, "R1 handshake state in reset", {ready, underrun}, 2'b10);
    rst_ni = 1'b1;
    for (int f = 0; f < nfr - 1; f++) begin
      bit do_load;
      wait (rise_cnt == f * FB + 30);
      do_load = (f == 0 || f == 2) ? 1'b1 : (f == 1 || f == 3) ? 1'b0 : ($urandom % 3 != 0);
      if (do_load) begin
        logic [FB-1:0] s;
        s = rand_set();
        @(negedge clk);
        valid   = 1'b1;
        samples = s;
        @(negedge clk);
        valid = 1'b0;
        chk(ready == 1'b0, "R6 ready low after accept", ready, 0);
        if (f == 2) begin
          // R6: offer while full is ignored
          valid   = 1'b1;
          samples = ~s;
          repeat (2) @(negedge clk);
          valid = 1'b0;
          chk(ready == 1'b0, "R6 ready stays low while full", ready, 0);
        end
        exp_set[f+1]   = s;
        exp_under[f+1] = 1'b0;
      end else begin
        exp_set[f+1]   = exp_set[f];
        exp_under[f+1] = 1'b1;
      end
      plan_max = f + 1;
    end
    wait (rise_cnt == nfr * FB + 2);
    chk(r3_bad == 0, "R3 changes only at sclk fall", r3_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4924));
    do_run(0, 12);
    do_run(3, 6);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rise_cnt, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule